// File: doc/BRIEF.md
# Quadrant-Interleaved Unit-Cell Selection Sequencer

This block drives a unary converter array built from four square quadrants of unit cells. The quadrants are named A1, A2, B1 and B2 and are placed as A1 and B1 on the upper row with B2 and A2 below. A binary input code says how many cells must be on. Consecutive codes visit the quadrants in the fixed order A1, A2, B1, B2, and only after all four have taken a cell does the within-quadrant rank advance. This spreads each increment across the whole array instead of filling one region. Inside a quadrant, the rank-to-position map is an 8x8 magic square by default. The A quadrants use the square directly and the B quadrants use a rotated copy, so neighbouring ranks sit far apart and the errors of the selected cells average out.

For every code the block gives several registered results: the fill count of each quadrant, a per-cell enable vector, and the quadrant and rank of the cell that the code switched on last. The quadrant side is a parameter and must be a multiple of 4. The largest meaningful code is four times the quadrant cell count.

Top module: `msq_cell_sequencer`

## Requirements
- R1: While `rst` is high at a clock edge, every output is zero after that edge: `fill_cnt`, `cell_en`, `last_quad`, `last_rank` and `last_vld`.
- R2: A code above 4*Q (Q = SIDE*SIDE cells per quadrant, 64 by default) is treated as exactly 4*Q.
- R3: For a clamped code k, the quadrants with sequence index q (A1=0, A2=1, B1=2, B2=3) get fill ceil((k-q)/4), or 0 when k <= q. Quadrant q's fill is `fill_cnt[q*FILL_W +: FILL_W]`.
- R4: The number of set bits in `cell_en` equals the clamped code.
- R5: Within each quadrant, the number of enabled cells equals that quadrant's fill count.
- R6: Cell (r,c) of quadrant q is bit `q*Q + r*SIDE + c` of `cell_en`. It is set when its stored value is at most the quadrant fill. The base value at (r,c) is idx = r*SIDE+c+1, replaced by SIDE*SIDE+1-idx when r%4 == c%4 or r%4 + c%4 == 3. A1 and A2 use the base value at (r,c). B1 and B2 use the base value at (c, SIDE-1-r), a quarter-turn counterclockwise.
- R7: For a clamped code k >= 1, `last_vld` is 1, `last_quad` = (k-1) mod 4 in sequence-index encoding, and `last_rank` = floor((k-1)/4)+1. For k = 0, `last_vld`, `last_quad` and `last_rank` are 0.
- R8: Outputs change only at a clock edge and reflect the code sampled at that edge, one cycle of latency.
- R9: Fill counts never increase along the order A1, A2, B1, B2, and A1 exceeds B2 by at most one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| code_in | input | CODE_W | Requested number of active cells |
| fill_cnt | output | 4*FILL_W | Per-quadrant fill counts, sequence order A1, A2, B1, B2 |
| cell_en | output | 4*Q | Per-cell enables, quadrant-major then row-major |
| last_quad | output | 2 | Sequence index of the most recently added cell's quadrant |
| last_rank | output | FILL_W | Rank of that cell within its quadrant |
| last_vld | output | 1 | High when the code is nonzero |

## Verification
The hardest states to reach are the ends of the range. These are the codes where B2 is the only quadrant still one cell short, the full-scale code, and codes beyond full scale that must saturate rather than wrap. The stimulus steps through these codes directly, along with the first four codes where each quadrant takes its first cell. It also drops from full scale straight back to a small code, so the bench can see that enables turn off correctly as well as on.

// File: rtl/msq_sel_pkg.sv
package msq_sel_pkg;

  typedef enum logic [1:0] {
    QUAD_A1 = 2'd0,
    QUAD_A2 = 2'd1,
    QUAD_B1 = 2'd2,
    QUAD_B2 = 2'd3
  } quad_e;

  localparam int NUM_QUAD = 4;

  // Doubly-even magic square entry, rows and columns counted from 0.
  function automatic int base_val(int side, int r, int c);
    int idx;
    int rm;
    int cm;
    idx = r * side + c + 1;
    rm  = r % 4;
    cm  = c % 4;
    if (rm == cm || rm + cm == 3) return side * side + 1 - idx;
    return idx;
  endfunction

  // Quarter-turn counterclockwise copy for the rotated quadrants.
  function automatic int cell_val(int side, bit rot, int r, int c);
    if (rot) return base_val(side, c, side - 1 - r);
    return base_val(side, r, c);
  endfunction

endpackage

// File: rtl/msq_code_split.sv
module msq_code_split #(
  parameter  int SIDE   = 8,
  localparam int Q      = SIDE * SIDE,
  localparam int MAXC   = 4 * Q,
  localparam int CODE_W = $clog2(MAXC + 1),
  localparam int FILL_W = $clog2(Q + 1)
) (
  input  logic [CODE_W-1:0] code_in,
  output logic [FILL_W-1:0] fill [msq_sel_pkg::NUM_QUAD],
  output logic [1:0]        last_quad,
  output logic [FILL_W-1:0] last_rank,
  output logic              last_vld
);

  logic [CODE_W-1:0] code_c;
  logic [CODE_W-1:0] step;

  // Saturate codes above full scale.
  assign code_c = (code_in > CODE_W'(MAXC)) ? CODE_W'(MAXC) : code_in;

  for (genvar q = 0; q < msq_sel_pkg::NUM_QUAD; q++) begin : g_fill
    logic [CODE_W-1:0] span;
    assign span    = code_c - CODE_W'(q) - CODE_W'(1);
    assign fill[q] = (code_c > CODE_W'(q)) ? FILL_W'(span >> 2) + FILL_W'(1) : '0;
  end

  assign step = code_c - CODE_W'(1);

  always_comb begin
    last_vld  = (code_c != '0);
    last_quad = '0;
    last_rank = '0;
    if (last_vld) begin
      last_quad = step[1:0];
      last_rank = FILL_W'(step >> 2) + FILL_W'(1);
    end
  end

endmodule

// File: rtl/msq_quad_cells.sv
module msq_quad_cells #(
  parameter  int SIDE   = 8,
  parameter  bit ROT    = 1'b0,
  localparam int Q      = SIDE * SIDE,
  localparam int FILL_W = $clog2(Q + 1)
) (
  input  logic [FILL_W-1:0] fill,
  output logic [Q-1:0]      en
);

  for (genvar r = 0; r < SIDE; r++) begin : g_row
    for (genvar c = 0; c < SIDE; c++) begin : g_col
      localparam int V = msq_sel_pkg::cell_val(SIDE, ROT, r, c);
      assign en[r*SIDE + c] = (fill >= FILL_W'(V));
    end
  end

endmodule

// File: rtl/msq_cell_sequencer.sv
module msq_cell_sequencer #(
  parameter  int SIDE   = 8,
  localparam int Q      = SIDE * SIDE,
  localparam int MAXC   = 4 * Q,
  localparam int CODE_W = $clog2(MAXC + 1),
  localparam int FILL_W = $clog2(Q + 1),
  localparam int NQ     = msq_sel_pkg::NUM_QUAD
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CODE_W-1:0]    code_in,
  output logic [NQ*FILL_W-1:0] fill_cnt,
  output logic [NQ*Q-1:0]      cell_en,
  output logic [1:0]           last_quad,
  output logic [FILL_W-1:0]    last_rank,
  output logic                 last_vld
);

  logic [FILL_W-1:0]    fill [NQ];
  logic [NQ*FILL_W-1:0] fill_nxt;
  logic [NQ*Q-1:0]      en_nxt;
  logic [1:0]           quad_nxt;
  logic [FILL_W-1:0]    rank_nxt;
  logic                 vld_nxt;

  msq_code_split #(.SIDE(SIDE)) i_split (
    .code_in   (code_in),
    .fill      (fill),
    .last_quad (quad_nxt),
    .last_rank (rank_nxt),
    .last_vld  (vld_nxt)
  );

  for (genvar q = 0; q < NQ; q++) begin : g_quad
    // Sequence indices 2 and 3 are the rotated B quadrants.
    msq_quad_cells #(.SIDE(SIDE), .ROT(q >= 2)) i_cells (
      .fill (fill[q]),
      .en   (en_nxt[q*Q +: Q])
    );
    assign fill_nxt[q*FILL_W +: FILL_W] = fill[q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill_cnt  <= '0;
      cell_en   <= '0;
      last_quad <= '0;
      last_rank <= '0;
      last_vld  <= 1'b0;
    end else begin
      fill_cnt  <= fill_nxt;
      cell_en   <= en_nxt;
      last_quad <= quad_nxt;
      last_rank <= rank_nxt;
      last_vld  <= vld_nxt;
    end
  end

endmodule

// File: rtl/msq_cell_sequencer_chk.sv
module msq_cell_sequencer_chk #(
  parameter  int SIDE   = 8,
  localparam int Q      = SIDE * SIDE,
  localparam int MAXC   = 4 * Q,
  localparam int CODE_W = $clog2(MAXC + 1),
  localparam int FILL_W = $clog2(Q + 1),
  localparam int NQ     = 4
) (
  input logic                 clk,
  input logic                 rst,
  input logic [CODE_W-1:0]    code_in,
  input logic [NQ*FILL_W-1:0] fill_cnt,
  input logic [NQ*Q-1:0]      cell_en,
  input logic [1:0]           last_quad,
  input logic [FILL_W-1:0]    last_rank,
  input logic                 last_vld
);

  logic primed;
  int   f0, f1, f2, f3;

  always_ff @(posedge clk) begin
    if (rst) primed <= 1'b0;
    else     primed <= 1'b1;
  end

  assign f0 = int'(fill_cnt[0*FILL_W +: FILL_W]);
  assign f1 = int'(fill_cnt[1*FILL_W +: FILL_W]);
  assign f2 = int'(fill_cnt[2*FILL_W +: FILL_W]);
  assign f3 = int'(fill_cnt[3*FILL_W +: FILL_W]);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cell_en == '0 && fill_cnt == '0 && !last_vld));

  // R4
  total_match_chk: assert property (@(posedge clk) disable iff (rst)
    primed |-> ($countones(cell_en) ==
      (($past(code_in) > CODE_W'(MAXC)) ? MAXC : int'($past(code_in)))));

  // R5
  for (genvar q = 0; q < NQ; q++) begin : g_qc
    quad_count_chk: assert property (@(posedge clk) disable iff (rst)
      $countones(cell_en[q*Q +: Q]) == int'(fill_cnt[q*FILL_W +: FILL_W]));
  end

  // R9
  fill_order_chk: assert property (@(posedge clk) disable iff (rst)
    (f0 >= f1 && f1 >= f2 && f2 >= f3 && f0 - f3 <= 1));

  // R7
  last_rank_chk: assert property (@(posedge clk) disable iff (rst)
    last_vld |-> (fill_cnt[last_quad*FILL_W +: FILL_W] == last_rank));

endmodule

bind msq_cell_sequencer msq_cell_sequencer_chk #(.SIDE(SIDE)) i_chk (.*);

// File: tb/test_msq_cell_sequencer.sv
`timescale 1ns/1ps
module test_msq_cell_sequencer;

  localparam int SIDE   = 8;
  localparam int Q      = SIDE * SIDE;
  localparam int MAXC   = 4 * Q;
  localparam int CODE_W = $clog2(MAXC + 1);
  localparam int FILL_W = $clog2(Q + 1);
  localparam int NC     = 4 * Q;
  localparam int NV     = 14;

  // code, fill A1, A2, B1, B2, last quad, last rank
  localparam int VEC [NV][7] = '{
    '{0,   0, 0, 0, 0,   0, 0},
    '{1,   1, 0, 0, 0,   0, 1},
    '{2,   1, 1, 0, 0,   1, 1},
    '{3,   1, 1, 1, 0,   2, 1},
    '{4,   1, 1, 1, 1,   3, 1},
    '{5,   2, 1, 1, 1,   0, 2},
    '{7,   2, 2, 2, 1,   2, 2},
    '{100, 25, 25, 25, 25, 3, 25},
    '{130, 33, 33, 32, 32, 1, 33},
    '{255, 64, 64, 64, 63, 2, 64},
    '{256, 64, 64, 64, 64, 3, 64},
    '{300, 64, 64, 64, 64, 3, 64},
    '{511, 64, 64, 64, 64, 3, 64},
    '{6,   2, 2, 1, 1,   1, 2}
  };

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic [CODE_W-1:0]   code_in = '0;
  logic [4*FILL_W-1:0] fill_cnt;
  logic [NC-1:0]       cell_en;
  logic [1:0]          last_quad;
  logic [FILL_W-1:0]   last_rank;
  logic                last_vld;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  msq_cell_sequencer #(.SIDE(SIDE)) i_msq_cell_sequencer (
    .clk(clk), .rst(rst), .code_in(code_in), .fill_cnt(fill_cnt),
    .cell_en(cell_en), .last_quad(last_quad), .last_rank(last_rank),
    .last_vld(last_vld)
  );

  function automatic int ref_base(int r, int c);
    int idx = r * SIDE + c + 1;
    if ((r % 4) == (c % 4) || (r % 4) + (c % 4) == 3) return SIDE * SIDE + 1 - idx;
    return idx;
  endfunction

  function automatic logic [NC-1:0] ref_cells(int fa1, int fa2, int fb1, int fb2);
    logic [NC-1:0] v = '0;
    int f [4];
    f[0] = fa1; f[1] = fa2; f[2] = fb1; f[3] = fb2;
    for (int q = 0; q < 4; q++)
      for (int r = 0; r < SIDE; r++)
        for (int c = 0; c < SIDE; c++) begin
          int val = (q >= 2) ? ref_base(c, SIDE - 1 - r) : ref_base(r, c);
          v[q*Q + r*SIDE + c] = (val <= f[q]);
        end
    return v;
  endfunction

  task automatic chk_int(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_vec(string tag, logic [NC-1:0] act, logic [NC-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  task automatic apply(int code);
    @(negedge clk);
    code_in = CODE_W'(code);
    @(negedge clk);
  endtask

  task automatic check_row(int i);
    int code = VEC[i][0];
    int e [4];
    for (int q = 0; q < 4; q++) e[q] = VEC[i][1+q];
    for (int q = 0; q < 4; q++)
      chk_int($sformatf("R3 code=%0d fill q%0d", code, q),
              int'(fill_cnt[q*FILL_W +: FILL_W]), e[q]);
    chk_int($sformatf("R4 code=%0d total", code), $countones(cell_en),
            (code > MAXC) ? MAXC : code);
    for (int q = 0; q < 4; q++)
      chk_int($sformatf("R5 code=%0d quad q%0d", code, q),
              $countones(cell_en[q*Q +: Q]), e[q]);
    chk_vec($sformatf("R6 code=%0d cells", code), cell_en,
            ref_cells(e[0], e[1], e[2], e[3]));
    chk_int($sformatf("R7 code=%0d vld", code), int'(last_vld), (code != 0) ? 1 : 0);
    chk_int($sformatf("R7 code=%0d quad", code), int'(last_quad), VEC[i][5]);
    chk_int($sformatf("R7 code=%0d rank", code), int'(last_rank), VEC[i][6]);
    chk_int($sformatf("R9 code=%0d order", code),
            int'(e[0] >= e[1] && e[1] >= e[2] && e[2] >= e[3] && e[0] - e[3] <= 1), 1);
    if (code > MAXC)
      chk_int($sformatf("R2 code=%0d clamp", code), $countones(cell_en), MAXC);
  endtask

  initial begin
    #(200000 * 5);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    // R1: reset with a nonzero code on the input
    code_in = CODE_W'(200);
    repeat (3) @(negedge clk);
    chk_vec("R1 reset cells", cell_en, '0);
    chk_int("R1 reset fill", int'(fill_cnt), 0);
    chk_int("R1 reset vld", int'(last_vld), 0);
    chk_int("R1 reset rank", int'(last_rank), 0);
    rst = 1'b0;
    code_in = '0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][0]);
      check_row(i);
    end

    // R8: full scale, then zero; no change before the edge
    apply(256);
    @(negedge clk);
    code_in = '0;
    #1;
    chk_int("R8 hold before edge", $countones(cell_en), 256);
    @(negedge clk);
    chk_int("R8 after edge", $countones(cell_en), 0);
    chk_int("R8 vld after edge", int'(last_vld), 0);

    // R1: reset mid-run, then recovery
    apply(100);
    rst = 1'b1;
    @(negedge clk);
    chk_vec("R1 mid reset cells", cell_en, '0);
    chk_int("R1 mid reset fill", int'(fill_cnt), 0);
    rst = 1'b0;
    @(negedge clk);
    chk_int("R4 after reset release", $countones(cell_en), 100);

    summary();
    $finish;
  end

endmodule